// File: doc/BRIEF.md
# Ternary Longest-Prefix Lookup Array

The block holds a small table of ternary rules. Each rule is a stored value, a care-mask, a valid bit and a next-hop word. A destination address is compared against every rule in the same cycle. A rule matches when every address bit that its mask marks as cared agrees with the stored value bit. Among the matching rules, the one at the lowest index wins. Its index selects the next-hop word, and that word is returned as the lookup result.

Software keeps the rules sorted so that longer prefixes sit at lower indices. With that ordering, the lowest-index match is also the longest matching prefix. An all-wildcard rule placed at the last used index serves as the default route. Lookups are pipelined at one per cycle with a fixed latency. The block does not reorder rules when one is written.

Top module: `tcam_lpm`

## Requirements
- R1: A valid rule matches an address when, for every bit position where its mask bit is 1, the address bit equals the stored value bit. Bits where the mask is 0 are ignored.
- R2: When several valid rules match, the result reports the lowest matching index.
- R3: Rules written longest prefix first return the longest matching prefix. A prefix of length L is a mask with L ones at the most significant end and zeros below.
- R4: On a hit, `res_nh_o` equals the next-hop word most recently written to the reported index.
- R5: A valid rule with an all-zero mask matches every address. At the last index it is returned only when no other rule matches.
- R6: Invalid rules never match. When no valid rule matches, a result has `res_hit_o`=0, `res_idx_o`=0 and `res_nh_o`=0.
- R7: A lookup presented with `lkp_vld_i`=1 at a rising edge produces `res_vld_o`=1 after the second rising edge that follows. No result appears without a lookup.
- R8: A write presented at a rising edge, covering value, mask, valid bit and next hop, is seen by lookups presented at later edges. A lookup presented at the same edge as the write sees the old rule and the old next hop.
- R9: While `rst_ni` is low, all rules are invalid and `res_vld_o` and `res_hit_o` are 0. The first lookup after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_vld_i | input | 1 | Lookup request |
| lkp_addr_i | input | ADDR_W | Destination address to look up |
| wr_en_i | input | 1 | Rule write strobe |
| wr_idx_i | input | IDX_W | Rule index to write |
| wr_valid_i | input | 1 | Valid bit written to the rule |
| wr_value_i | input | ADDR_W | Stored value bits |
| wr_mask_i | input | ADDR_W | Care-mask, 1 = bit compared |
| wr_nh_i | input | NH_W | Next-hop word for the rule |
| res_vld_o | output | 1 | Result valid |
| res_hit_o | output | 1 | A valid rule matched |
| res_idx_o | output | IDX_W | Index of the winning rule, 0 on miss |
| res_nh_o | output | NH_W | Next hop of the winning rule, 0 on miss |

## Verification
The hardest situation to reach is a write that lands at the same edge as a lookup of an address the rewritten rule covers. Here the old next hop must come back even though the write has already reached the table. The bench sets up that collision directly. It first loads a rule with one next hop, then issues the overwrite and a lookup at the same edge, followed by a second lookup one cycle later. It expects two different words. Random tables mix prefix masks with arbitrary masks, and lookup addresses are often built from a stored value with only its don't-care bits flipped. This makes overlapping multi-rule matches common rather than rare.

// File: rtl/tcam_lpm_pkg.sv
package tcam_lpm_pkg;
  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/tcam_lpm_store.sv
module tcam_lpm_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_value_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic [ADDR_W-1:0] key_i,
  output logic [DEPTH-1:0]  match_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ADDR_W-1:0] val_q, msk_q;
    logic              vld_q;
    logic              sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        msk_q <= '0;
        vld_q <= 1'b0;
      end else if (sel) begin
        val_q <= wr_value_i & wr_mask_i;
        msk_q <= wr_mask_i;
        vld_q <= wr_valid_i;
      end
    end

    assign match_o[g] = vld_q && (((key_i & msk_q) ^ val_q) == '0);
  end
endmodule

// File: rtl/tcam_lpm_penc.sv
module tcam_lpm_penc #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [DEPTH-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tcam_lpm_nh_ram.sv
module tcam_lpm_nh_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NH_W  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [NH_W-1:0]  wr_nh_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [NH_W-1:0]  rd_nh_o
);
  // write staged one cycle so it lines up with the match-vector stage
  logic             pend_q;
  logic [IDX_W-1:0] pidx_q;
  logic [NH_W-1:0]  pnh_q;
  logic [NH_W-1:0]  mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
      pnh_q  <= '0;
    end else begin
      pend_q <= wr_en_i;
      pidx_q <= wr_idx_i;
      pnh_q  <= wr_nh_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (pend_q && (pidx_q == IDX_W'(g)))      mem_q[g] <= pnh_q;
    end
  end

  assign rd_nh_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm
  import tcam_lpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned NH_W   = 8,
  localparam int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_vld_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_value_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic [NH_W-1:0]   wr_nh_i,
  output logic              res_vld_o,
  output logic              res_hit_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic [NH_W-1:0]   res_nh_o
);
  logic [DEPTH-1:0] match_d, match_q;
  logic             s1_vld_q;
  logic             enc_any;
  logic [IDX_W-1:0] enc_idx;
  logic [NH_W-1:0]  rd_nh;
  logic             win;

  tcam_lpm_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_value_i, .wr_mask_i,
    .key_i  (lkp_addr_i),
    .match_o(match_d)
  );

  // stage 1: registered match vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      match_q  <= '0;
    end else begin
      s1_vld_q <= lkp_vld_i;
      match_q  <= lkp_vld_i ? match_d : '0;
    end
  end

  tcam_lpm_penc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_penc (
    .req_i(match_q), .any_o(enc_any), .idx_o(enc_idx)
  );

  tcam_lpm_nh_ram #(.DEPTH(DEPTH), .NH_W(NH_W), .IDX_W(IDX_W)) u_nh (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_nh_i,
    .rd_idx_i(enc_idx), .rd_nh_o(rd_nh)
  );

  assign win = s1_vld_q && enc_any;

  // stage 2: encode + next-hop read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o <= 1'b0;
      res_hit_o <= 1'b0;
      res_idx_o <= '0;
      res_nh_o  <= '0;
    end else begin
      res_vld_o <= s1_vld_q;
      res_hit_o <= win;
      res_idx_o <= win ? enc_idx : '0;
      res_nh_o  <= win ? rd_nh : '0;
    end
  end
endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned NH_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_vld_i,
  input logic             res_vld_o,
  input logic             res_hit_o,
  input logic [IDX_W-1:0] res_idx_o,
  input logic [NH_W-1:0]  res_nh_o
);
  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_vld_i |=> ##1 res_vld_o);
  assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_vld_i |=> ##1 !res_vld_o);
  assert_miss_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !res_hit_o) |-> (res_idx_o == '0 && res_nh_o == '0));
  assert_hit_in_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_vld_o);
  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!res_vld_o && !res_hit_o));
endmodule

bind tcam_lpm tcam_lpm_chk #(.IDX_W(IDX_W), .NH_W(NH_W)) u_chk (
  .clk_i, .rst_ni, .lkp_vld_i, .res_vld_o, .res_hit_o, .res_idx_o, .res_nh_o
);

// File: tb/tcam_lpm_tb.sv
`timescale 1ns/1ps
module tcam_lpm_tb;
  localparam int AW = 8, DEPTH = 8, NW = 8, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkp_vld = 1'b0, wr_en = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] lkp_addr = '0, wr_value = '0, wr_mask = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [NW-1:0] wr_nh = '0;
  logic res_vld, res_hit;
  logic [IW-1:0] res_idx;
  logic [NW-1:0] res_nh;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_val [DEPTH];
  logic [AW-1:0] m_msk [DEPTH];
  logic          m_vld [DEPTH];
  logic [NW-1:0] m_nh  [DEPTH];

  always #10 clk = ~clk;

  tcam_lpm #(.ADDR_W(AW), .DEPTH(DEPTH), .NH_W(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lkp_vld_i(lkp_vld), .lkp_addr_i(lkp_addr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid),
    .wr_value_i(wr_value), .wr_mask_i(wr_mask), .wr_nh_i(wr_nh),
    .res_vld_o(res_vld), .res_hit_o(res_hit), .res_idx_o(res_idx), .res_nh_o(res_nh)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pmask(input int len);
    logic [AW-1:0] ones = '1;
    return (len == 0) ? '0 : ones << (AW - len);
  endfunction

  function automatic void ref_lkp(input logic [AW-1:0] a, output logic h,
                                  output logic [IW-1:0] ix, output logic [NW-1:0] nh);
    h = 0; ix = '0; nh = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (m_vld[i] && (((a ^ m_val[i]) & m_msk[i]) == '0)) begin
        h = 1; ix = IW'(i); nh = m_nh[i];
      end
  endfunction

  task automatic wr(input int i, input logic v, input logic [AW-1:0] val,
                    input logic [AW-1:0] msk, input logic [NW-1:0] nh);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(i); wr_valid = v; wr_value = val; wr_mask = msk; wr_nh = nh;
    m_vld[i] = v; m_val[i] = val; m_msk[i] = msk; m_nh[i] = nh;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < DEPTH; i++) wr(i, 0, '0, '0, '0);
  endtask

  task automatic lkp(input logic [AW-1:0] a, input string tag);
    logic h; logic [IW-1:0] ix; logic [NW-1:0] nh;
    ref_lkp(a, h, ix, nh);
    @(negedge clk);
    lkp_vld = 1; lkp_addr = a;
    @(negedge clk);
    lkp_vld = 0;
    @(negedge clk);
    chk({tag, " R7 vld"}, 32'(res_vld), 32'd1);
    chk({tag, " hit"}, 32'(res_hit), 32'(h));
    chk({tag, " idx"}, 32'(res_idx), 32'(ix));
    chk({tag, " nh R4"}, 32'(res_nh), 32'(nh));
  endtask

  initial begin
    logic h; logic [IW-1:0] ix; logic [NW-1:0] nh;
    void'($urandom(32'd7321));
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_nh[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R9 vld in reset", 32'(res_vld), 0);
    chk("R9 hit in reset", 32'(res_hit), 0);
    rst_n = 1;
    lkp(8'hA5, "R9 empty table");
    // no-lookup cycles produce no result
    repeat (3) @(negedge clk);
    chk("R7 idle", 32'(res_vld), 0);

    // R1: value 00101100 mask 11011101, bits 5 and 1 ignored
    wr(3, 1, 8'b0010_1100, 8'b1101_1101, 8'h33);
    lkp(8'b0010_1100, "R1 exact");
    lkp(8'b0010_1110, "R1 bit1 free");
    lkp(8'b0000_1100, "R1 bit5 free");
    lkp(8'b0000_1110, "R1 both free");
    lkp(8'b0010_1101, "R1 cared bit0 miss");
    lkp(8'b1010_1100, "R1 cared bit7 miss");
    // R6: invalidate, same address misses
    wr(3, 0, 8'b0010_1100, 8'b1101_1101, 8'h33);
    lkp(8'b0010_1100, "R6 invalid");

    // R3/R5: 011*,000*,11*,01*,00*,0*,* sorted longest first
    wr(0, 1, 8'b0110_0000, pmask(3), 8'h17);
    wr(1, 1, 8'b0000_0000, pmask(3), 8'h16);
    wr(2, 1, 8'b1100_0000, pmask(2), 8'h15);
    wr(3, 1, 8'b0100_0000, pmask(2), 8'h14);
    wr(4, 1, 8'b0000_0000, pmask(2), 8'h13);
    wr(5, 1, 8'b0000_0000, pmask(1), 8'h12);
    wr(6, 1, 8'b0000_0000, pmask(0), 8'h11);
    lkp(8'b0110_0100, "R3 011*");
    lkp(8'b0101_0000, "R3 01*");
    lkp(8'b0011_1111, "R3 00*");
    lkp(8'b0001_0000, "R3 000* wins R2");
    lkp(8'b1000_0001, "R5 default");
    lkp(8'b1110_0000, "R3 11*");

    // R8: overwrite rule 0 next hop in the same cycle as a lookup
    @(negedge clk);
    ref_lkp(8'b0110_0100, h, ix, nh);
    chk("R8 setup", 32'(nh), 32'h17);
    wr_en = 1; wr_idx = 0; wr_valid = 1; wr_value = 8'b0110_0000; wr_mask = pmask(3); wr_nh = 8'h2A;
    lkp_vld = 1; lkp_addr = 8'b0110_0100;
    m_nh[0] = 8'h2A;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    lkp_vld = 0;
    chk("R8 same-cycle old nh", 32'(res_nh), 32'h17);
    chk("R8 same-cycle old idx", 32'(res_idx), 0);
    @(negedge clk);
    chk("R8 next-cycle new nh", 32'(res_nh), 32'h2A);
    // R8: invalidate rule 0 alongside lookup; old hit then fallback to 01*
    @(negedge clk);
    wr_en = 1; wr_idx = 0; wr_valid = 0;
    lkp_vld = 1; lkp_addr = 8'b0110_0100;
    m_vld[0] = 0;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    lkp_vld = 0;
    chk("R8 old rule idx", 32'(res_idx), 0);
    @(negedge clk);
    chk("R8 new rule idx", 32'(res_idx), 3);
    chk("R8 new rule nh", 32'(res_nh), 32'h14);

    // R5 alone at last index
    clear_all();
    wr(DEPTH - 1, 1, 8'h5A, '0, 8'hEE);
    for (int k = 0; k < 6; k++) lkp(8'($urandom), "R5 only default");

    // random tables, overlapping matches (R1 R2 R4 R6)
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [AW-1:0] msk;
        msk = ($urandom % 2) ? pmask(int'($urandom % (AW + 1))) : AW'($urandom);
        wr(i, ($urandom % 5) != 0, AW'($urandom), msk, NW'($urandom));
      end
      for (int k = 0; k < 15; k++) begin
        int e = int'($urandom % DEPTH);
        logic [AW-1:0] a;
        a = ($urandom % 3 == 0) ? AW'($urandom) : (m_val[e] ^ (AW'($urandom) & ~m_msk[e]));
        lkp(a, "R2 random");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule